// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Rounded, Saturated Output

This block multiplies two signed 18-bit operands on every clock and folds the product into a wide registered accumulator. A per-cycle `load` input picks between two actions. With `load` set, a new running sum starts from the current product. With `load` clear, the product is combined with the value already held. Whether that combination adds or subtracts is fixed when the block is elaborated.

The accumulator moves only on cycles where `valid` is high. Its raw contents are available on an output port. A rounding stage and a saturation stage turn those contents into a narrower result. When that result does not fit, an overflow flag is raised. Rounding and clamping are each selected by a parameter.

A typical use is a filter tap or dot-product engine. Pulse `load` on the first term of each sum, then stream the remaining terms with `load` low.

Top module: `mac_rs_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator is cleared to zero whatever the other inputs are. After that edge, `acc_raw` = 0, `res` = 0 and `ovf` = 0.
- R2: When `valid` is low at a rising edge, the accumulator keeps its value. The values on `load`, `op_a` and `op_b` have no effect.
- R3: When `valid` and `load` are both high at a rising edge, the accumulator takes the two's-complement product `op_a * op_b`, sign-extended to the accumulator width. Its earlier contents are discarded.
- R4: With the direction parameter `DIR` = `ACC_ADD`, `valid` high and `load` low at an edge, the accumulator becomes its previous value plus the product.
- R5: With `DIR` = `ACC_SUB`, `valid` high and `load` low at an edge, the accumulator becomes its previous value minus the product.
- R6: The accumulator is 44 bits wide (36 product bits and 8 guard bits). Sums wrap modulo 2^44 as two's complement. `acc_raw` shows all 44 bits.
- R7: With rounding enabled, the result is floor((acc + 2^(DROP_W-1)) / 2^DROP_W), so exact halves round toward plus infinity. `res` and `ovf` follow the accumulator register with no added register stage.
- R8: If the rounded value lies above 2^(OUT_W-1)-1 or below -2^(OUT_W-1), `ovf` is 1. With saturation enabled, `res` is then clamped to the nearest of those two limits. Otherwise `ovf` is 0 and `res` is the rounded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 18 | Signed multiplicand |
| op_b | input | 18 | Signed multiplier |
| load | input | 1 | 1: start a new sum from the product; 0: combine the product with the held sum |
| valid | input | 1 | Qualifies the operands; the accumulator updates only when high |
| acc_raw | output | 44 | Full accumulator contents, two's complement |
| res | output | OUT_W (16) | Rounded and saturated result |
| ovf | output | 1 | High while the rounded accumulator exceeds the `res` range |

## Verification
The bench builds two copies of the unit side by side and drives both with the same stimulus.
- The first uses the defaults: adding direction, rounding and saturation on, 16 bits dropped, 16-bit result. With these settings the rounding midpoint can be reached from an 18-bit operand, and a single full-scale product already pushes `res` into saturation.
- The second is identical except that it subtracts, so the subtracting path is exercised on the same operand stream.

Holding the accumulate path at full-scale products for about 512 cycles carries the 44-bit register past its positive limit, which brings the wrap-around within reach.

// File: rtl/mac_pkg.sv
// Package: mac_pkg
// Shared constants and types for the multiply-accumulate unit.
// Assumes nothing beyond a two's-complement datapath.
package mac_pkg;

    // Direction of the accumulate path, chosen at elaboration.
    typedef enum logic {
        ACC_ADD = 1'b0,
        ACC_SUB = 1'b1
    } acc_dir_e;

    // Default operand width and the extra headroom bits above the product.
    localparam int unsigned OPND_W_DEF  = 18;
    localparam int unsigned GUARD_W_DEF = 8;

endpackage

// File: rtl/mac_mult.sv
// Module: mac_mult
// Signed multiplier. Forms a_i * b_i in two's complement and sign-extends
// the full-precision product to the accumulator width.
// Assumes: OUT_W >= A_W + B_W. Purely combinational.
module mac_mult #(
    parameter int unsigned A_W   = 18,
    parameter int unsigned B_W   = 18,
    parameter int unsigned OUT_W = 44
) (
    input  logic signed [A_W-1:0]   a_i,
    input  logic signed [B_W-1:0]   b_i,
    output logic signed [OUT_W-1:0] prod_o
);

    localparam int unsigned PROD_W = A_W + B_W;
    localparam int unsigned EXT_W  = OUT_W - PROD_W;

    logic signed [PROD_W-1:0] prod_full;

    // Full-precision signed product.
    always_comb begin
        prod_full = a_i * b_i;
    end

    // Sign extension up to the accumulator width (no extension when none is needed).
    generate
        if (EXT_W > 0) begin : g_ext
            assign prod_o = {{EXT_W{prod_full[PROD_W-1]}}, prod_full};
        end else begin : g_noext
            assign prod_o = prod_full;
        end
    endgenerate

endmodule

// File: rtl/mac_accum.sv
// Module: mac_accum
// Registered accumulator. On a qualified cycle it either loads the incoming
// product or folds it into the held sum. Whether it adds or subtracts
// depends on DIR, which is fixed at elaboration.
// Assumes: synchronous active-low reset; wraps modulo 2^ACC_W.
module mac_accum
    import mac_pkg::*;
#(
    parameter int unsigned ACC_W = 44,
    parameter acc_dir_e    DIR   = ACC_ADD
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic                    load_i,
    input  logic signed [ACC_W-1:0] prod_i,
    output logic signed [ACC_W-1:0] acc_o
);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] fold;

    // Feedback combination, built for the chosen direction.
    generate
        if (DIR == ACC_SUB) begin : g_sub
            always_comb begin
                fold = acc_q - prod_i;
            end
        end else begin : g_add
            always_comb begin
                fold = acc_q + prod_i;
            end
        end
    endgenerate

    // Accumulator register: clear on reset, load or fold on valid, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (valid_i) begin
            if (load_i) begin
                acc_q <= prod_i;
            end else begin
                acc_q <= fold;
            end
        end
    end

    assign acc_o = acc_q;

    // R1: a reset edge leaves the register at zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> acc_q == '0);

    // R2: an unqualified cycle changes nothing.
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(acc_q));

    // R3: a qualified load takes the product alone.
    assert_load_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && load_i) |=> acc_q == $past(prod_i));

    generate
        if (DIR == ACC_SUB) begin : g_chk_sub
            // R5: the subtracting build removes the product from the old sum.
            assert_fold_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_i && !load_i) |=> acc_q == $past(acc_q) - $past(prod_i));
        end else begin : g_chk_add
            // R4: the adding build adds the product to the old sum.
            assert_fold_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_i && !load_i) |=> acc_q == $past(acc_q) + $past(prod_i));
        end
    endgenerate

endmodule

// File: rtl/mac_round_sat.sv
// Module: mac_round_sat
// Output conditioning. Drops DROP_W low bits of the accumulator, optionally
// rounding exact halves upward, then checks the result against the signed
// OUT_W range. The flag reports any out-of-range value; SAT_EN selects
// whether such values are clamped or simply truncated.
// Assumes: DROP_W < ACC_W and ACC_W + 1 - DROP_W >= OUT_W. Combinational;
// clk and rst_n only clock the assertions.
module mac_round_sat #(
    parameter int unsigned ACC_W    = 44,
    parameter int unsigned DROP_W   = 16,
    parameter int unsigned OUT_W    = 16,
    parameter bit          ROUND_EN = 1'b1,
    parameter bit          SAT_EN   = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] acc_i,
    output logic signed [OUT_W-1:0] res_o,
    output logic                    ovf_o
);

    localparam int unsigned EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] SMAX = (EXT_W'(1) << (OUT_W - 1)) - EXT_W'(1);
    localparam logic signed [EXT_W-1:0] SMIN = ~SMAX;

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] scaled;
    logic                    above;
    logic                    below;

    // One extra sign bit so the rounding offset can never wrap.
    assign ext = {acc_i[ACC_W-1], acc_i};

    // Scaling, with or without the half-LSB offset.
    generate
        if (ROUND_EN && (DROP_W > 0)) begin : g_round
            localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) << (DROP_W - 1);
            logic signed [EXT_W-1:0] biased;
            always_comb begin
                biased = ext + HALF;
                scaled = biased >>> DROP_W;
            end
        end else begin : g_trunc
            always_comb begin
                scaled = ext >>> DROP_W;
            end
        end
    endgenerate

    // Range detection against the signed output limits.
    always_comb begin
        above = scaled > SMAX;
        below = scaled < SMIN;
    end

    assign ovf_o = above | below;

    // Output selection: clamp when saturation is built in, otherwise wrap.
    generate
        if (SAT_EN) begin : g_sat
            always_comb begin
                if (above) begin
                    res_o = SMAX[OUT_W-1:0];
                end else if (below) begin
                    res_o = SMIN[OUT_W-1:0];
                end else begin
                    res_o = scaled[OUT_W-1:0];
                end
            end

            // R8: a raised flag always comes with a clamped result.
            assert_ovf_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ovf_o |-> (res_o == SMAX[OUT_W-1:0] || res_o == SMIN[OUT_W-1:0]));

            // R8: a positive accumulator never produces a negative result, and vice versa.
            assert_sign_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_i != '0) |-> (res_o == '0 || res_o[OUT_W-1] == acc_i[ACC_W-1]));
        end else begin : g_wrap
            always_comb begin
                res_o = scaled[OUT_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/mac_rs_unit.sv
// Module: mac_rs_unit (top)
// Signed multiply-accumulate unit with a load control and a rounded,
// saturated output. Chain: multiplier -> accumulator register -> output
// conditioning. Results are visible one edge after the qualifying inputs.
// Assumes: synchronous active-low reset; DIR is fixed at elaboration.
module mac_rs_unit
    import mac_pkg::*;
#(
    parameter int unsigned A_W      = OPND_W_DEF,
    parameter int unsigned B_W      = OPND_W_DEF,
    parameter int unsigned GUARD_W  = GUARD_W_DEF,
    parameter acc_dir_e    DIR      = ACC_ADD,
    parameter int unsigned DROP_W   = 16,
    parameter int unsigned OUT_W    = 16,
    parameter bit          ROUND_EN = 1'b1,
    parameter bit          SAT_EN   = 1'b1,
    localparam int unsigned ACC_W   = A_W + B_W + GUARD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [A_W-1:0]   op_a,
    input  logic signed [B_W-1:0]   op_b,
    input  logic                    load,
    input  logic                    valid,
    output logic signed [ACC_W-1:0] acc_raw,
    output logic signed [OUT_W-1:0] res,
    output logic                    ovf
);

    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] acc_q;

    // Product stage.
    mac_mult #(
        .A_W   (A_W),
        .B_W   (B_W),
        .OUT_W (ACC_W)
    ) u_mult (
        .a_i    (op_a),
        .b_i    (op_b),
        .prod_o (prod_ext)
    );

    // Accumulator register.
    mac_accum #(
        .ACC_W (ACC_W),
        .DIR   (DIR)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid),
        .load_i  (load),
        .prod_i  (prod_ext),
        .acc_o   (acc_q)
    );

    // Output conditioning.
    mac_round_sat #(
        .ACC_W    (ACC_W),
        .DROP_W   (DROP_W),
        .OUT_W    (OUT_W),
        .ROUND_EN (ROUND_EN),
        .SAT_EN   (SAT_EN)
    ) u_rs (
        .clk   (clk),
        .rst_n (rst_n),
        .acc_i (acc_q),
        .res_o (res),
        .ovf_o (ovf)
    );

    assign acc_raw = acc_q;

    // R1: the outputs are quiet after a reset edge.
    assert_reset_outputs_R1: assert property (@(posedge clk)
        !rst_n |=> (res == '0 && !ovf && acc_raw == '0));

endmodule

// File: tb/tb_mac_rs_unit.sv
`timescale 1ns/100ps
module tb_mac_rs_unit;
    import mac_pkg::*;

    logic               clk;
    logic               rst_n;
    logic signed [17:0] op_a;
    logic signed [17:0] op_b;
    logic               load;
    logic               valid;
    logic signed [43:0] acc_raw, acc_raw_s;
    logic signed [15:0] res, res_s;
    logic               ovf, ovf_s;

    int checks   = 0;
    int failures = 0;

    // Software reference state, built from the requirements.
    logic signed [43:0] m_add;
    logic signed [43:0] m_sub;

    mac_rs_unit dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .load(load),
        .valid(valid), .acc_raw(acc_raw), .res(res), .ovf(ovf)
    );

    mac_rs_unit #(.DIR(ACC_SUB)) dut_sub (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .load(load),
        .valid(valid), .acc_raw(acc_raw_s), .res(res_s), .ovf(ovf_s)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct packed {
        logic signed [17:0] a;
        logic signed [17:0] b;
        logic               ld;
        logic               vl;
        logic signed [63:0] exp_acc;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{18'sd3,       18'sd4,       1'b1, 1'b1, 64'sd12},
        '{18'sd5,       18'sd6,       1'b0, 1'b1, 64'sd42},
        '{-18'sd7,      18'sd2,       1'b0, 1'b1, 64'sd28},
        '{18'sd100,     18'sd100,     1'b0, 1'b0, 64'sd28},
        '{18'sd9,       18'sd9,       1'b1, 1'b0, 64'sd28},
        '{-18'sd3,      -18'sd5,      1'b1, 1'b1, 64'sd15},
        '{-18'sd20,     18'sd10,      1'b0, 1'b1, -64'sd185},
        '{18'sd131071,  18'sd131071,  1'b1, 1'b1, 64'sd17179607041},
        '{-18'sd131072, 18'sd131071,  1'b0, 1'b1, -64'sd131071},
        '{-18'sd131072, -18'sd131072, 1'b1, 1'b1, 64'sd17179869184}
    };

    // Reference result per R7 and R8: round half up by 16 bits, clamp to 16 bits.
    function automatic longint ref_res(input logic signed [43:0] acc);
        longint s;
        s = (longint'(acc) + 64'sd32768) >>> 16;
        if (s > 32767)  return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    function automatic logic ref_ovf(input logic signed [43:0] acc);
        longint s;
        s = (longint'(acc) + 64'sd32768) >>> 16;
        return (s > 32767) || (s < -32768);
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs, advance the model, and sample after the edge.
    task automatic apply(input logic signed [17:0] a, input logic signed [17:0] b,
                         input logic ld, input logic vl);
        logic signed [43:0] p;
        @(negedge clk);
        op_a = a; op_b = b; load = ld; valid = vl;
        p = a * b;
        if (!rst_n) begin
            m_add = '0; m_sub = '0;
        end else if (vl) begin
            m_add = ld ? p : m_add + p;
            m_sub = ld ? p : m_sub - p;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic check_outputs(input string req);
        check(req, "acc_raw", longint'(acc_raw), longint'(m_add));
        check(req, "res", longint'(res), ref_res(m_add));
        check(req, "ovf", longint'(ovf), longint'(ref_ovf(m_add)));
    endtask

    // Watchdog: a hung run still counts as a failure and prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_a = '0; op_b = '0; load = 1'b0; valid = 1'b0;
        m_add = '0; m_sub = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_outputs("R1");

        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 idle hold, R3 load, R4 add, R5 subtract build, R8 saturation
        foreach (TBL[i]) begin
            apply(TBL[i].a, TBL[i].b, TBL[i].ld, TBL[i].vl);
            check("R3/R4/R2", "acc_raw table", longint'(acc_raw), longint'(TBL[i].exp_acc));
            check("R7/R8", "res table", longint'(res), ref_res(TBL[i].exp_acc[43:0]));
            check("R8", "ovf table", longint'(ovf), longint'(ref_ovf(TBL[i].exp_acc[43:0])));
            check("R5", "acc_raw subtract build", longint'(acc_raw_s), longint'(m_sub));
        end

        // R2: idle cycle with a load request and large operands changes nothing.
        apply(18'sd3, 18'sd4, 1'b1, 1'b1);
        apply(-18'sd131072, 18'sd131071, 1'b1, 1'b0);
        check("R2", "acc_raw idle load", longint'(acc_raw), 64'sd12);

        // R7: rounding boundaries around half an output LSB.
        apply(18'sd1, 18'sd32768, 1'b1, 1'b1);   check("R7", "res +half", longint'(res), 1);
        apply(18'sd1, 18'sd32767, 1'b1, 1'b1);   check("R7", "res below half", longint'(res), 0);
        apply(-18'sd1, 18'sd32768, 1'b1, 1'b1);  check("R7", "res -half", longint'(res), 0);
        apply(-18'sd1, 18'sd32769, 1'b1, 1'b1);  check("R7", "res below -half", longint'(res), -1);
        apply(18'sd1, 18'sd98304, 1'b1, 1'b1);   check("R7", "res 1.5", longint'(res), 2);

        // R8: positive limit reached exactly, then exceeded by half an LSB.
        apply(18'sd32767, 18'sd65536, 1'b1, 1'b1);
        check("R8", "res at max", longint'(res), 32767);
        check("R8", "ovf at max", longint'(ovf), 0);
        apply(18'sd1, 18'sd32768, 1'b0, 1'b1);
        check("R8", "res clamp max", longint'(res), 32767);
        check("R8", "ovf above max", longint'(ovf), 1);

        // R8: negative limit reached exactly, then exceeded.
        apply(-18'sd32768, 18'sd65536, 1'b1, 1'b1);
        check("R8", "res at min", longint'(res), -32768);
        check("R8", "ovf at min", longint'(ovf), 0);
        apply(-18'sd1, 18'sd32769, 1'b0, 1'b1);
        check("R8", "res clamp min", longint'(res), -32768);
        check("R8", "ovf below min", longint'(ovf), 1);

        // R6: 512 full-scale products carry the 44-bit sum around to -2^43.
        apply(-18'sd131072, -18'sd131072, 1'b1, 1'b1);
        for (int k = 0; k < 511; k++) begin
            apply(-18'sd131072, -18'sd131072, 1'b0, 1'b1);
        end
        check("R6", "acc_raw wrapped", longint'(acc_raw), -64'sd8796093022208);
        check_outputs("R6");
        check("R6", "acc_raw wrapped subtract build", longint'(acc_raw_s), longint'(m_sub));

        // R1: reset in the middle of a qualified load wins.
        @(negedge clk);
        rst_n = 1'b0;
        apply(18'sd77, 18'sd77, 1'b1, 1'b1);
        check_outputs("R1");
        check("R1", "acc_raw subtract build", longint'(acc_raw_s), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule